// File: doc/BRIEF.md
# SPI Command Frame Receiver

This block is the device-side serial port of a converter-style peripheral. A host frames each transaction with an active-low chip-select. While the frame is open, the block samples SDI on every rising SCLK edge into a 22-bit command shift register. It also counts the SCLK edges with a saturating counter. When chip-select rises, the block classifies the frame by that count. A frame with fewer than 22 clocks is short and is dropped as a no-operation. A frame with exactly 22 clocks is optimal, and a frame with more is long. In both of these cases the last 22 bits shifted in are passed to a command decoder.

The decoder supports two commands: a write to, and a read from, a small bank of 8-bit control registers. The bank contents are also driven out in parallel to the rest of the converter. A read command does not answer in its own frame. The register value is returned on SDO in the frame that follows. In every other frame, SDO carries the 16-bit conversion value presented on `conv_data`, which is captured when the frame opens.

SCLK, chip-select and SDI are treated as asynchronous. They are resynchronized into the system clock domain, which must run at least several times faster than SCLK.

Top module: `spi_cmd_frame_rx`

## Requirements
- R1: After reset, every control register reads zero, `ctrl_regs` is all zeros, and SDO is low while chip-select is high.
- R2: SDI is sampled on each rising SCLK edge while chip-select is low and shifted MSB-first into a 22-bit register.
- R3: The per-frame SCLK counter saturates at its maximum, so a frame of any length (for example 70 clocks) is still classified as long.
- R4: A frame with fewer than 22 SCLK edges is a no-operation: no register changes and no read response is armed.
- R5: A frame with exactly 22 SCLK edges has its 22 bits decoded as a command word laid out as opcode[21:17], address[16:8], data[7:0].
- R6: A frame with more than 22 SCLK edges decodes only the last 22 bits shifted in, so the command is right-justified in the frame.
- R7: Opcode 5'b00001 writes the data field into the control register selected by the address field.
- R8: Opcode 5'b00010 arms a read response; the next frame shifts out the selected register value in SDO bits 21:14, followed by zeros in bits 13:0.
- R9: When no read response is armed, a frame shifts out the `conv_data` value captured at the chip-select falling edge in SDO bits 21:6, followed by zeros in bits 5:0.
- R10: Every opcode other than 5'b00001 and 5'b00010 is a no-operation.
- R11: A write to an address at or above the register count is ignored, and a read of such an address returns zero.
- R12: SDO presents bit 21 before the first rising SCLK edge, advances one bit on each falling SCLK edge, and is zero for every bit after the 22nd.
- R13: An armed read response is consumed by the very next frame, whatever its length; a later frame returns conversion data again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, several times faster than SCLK |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Active-low frame select from the host |
| sclk | input | 1 | Serial clock from the host |
| sdi | input | 1 | Serial data in, sampled on rising SCLK |
| conv_data | input | 16 | Conversion result to shift out when no read is pending |
| sdo | output | 1 | Serial data out, updated on falling SCLK |
| ctrl_regs | output | NREG*8 | Control register bank, register 0 in the low byte |

## Verification
The assertions take two things for granted. First, chip-select and SCLK each hold for several system clocks, so that a resynchronized rising edge, falling edge or frame boundary never coincides with another edge. Second, a frame's opening and closing edges are separated by at least one system clock. The stimulus holds every SCLK phase for six system clocks. It opens and closes chip-select with ten idle clocks around each frame, and it changes SDI only while SCLK is low. Together these keep the resynchronized inputs inside those limits.

// File: rtl/spi_cmd_pkg.sv
package spi_cmd_pkg;

    localparam int WORD_W  = 22;
    localparam int OP_W    = 5;
    localparam int ADDR_W  = 9;
    localparam int DATA_W  = 8;
    localparam int CONV_W  = 16;
    localparam int CNT_W   = $clog2(WORD_W + 1) + 1;
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    localparam logic [OP_W-1:0] OPC_WRITE = 5'b00001;
    localparam logic [OP_W-1:0] OPC_READ  = 5'b00010;

    typedef struct packed {
        logic [OP_W-1:0]   opc;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
    } cmd_word_t;

    typedef enum logic [1:0] {
        FK_SHORT   = 2'd0,
        FK_OPTIMAL = 2'd1,
        FK_LONG    = 2'd2
    } frame_kind_e;

    typedef struct packed {
        logic sclk_rise;
        logic sclk_fall;
        logic frame_start;
        logic frame_end;
        logic sdi_bit;
    } spi_evt_t;

    function automatic frame_kind_e classify(input logic [CNT_W-1:0] n);
        if (n < CNT_W'(WORD_W))       return FK_SHORT;
        else if (n == CNT_W'(WORD_W)) return FK_OPTIMAL;
        else                          return FK_LONG;
    endfunction

endpackage

// File: rtl/spi_sync_edges.sv
module spi_sync_edges
    import spi_cmd_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     cs_n,
    input  logic     sclk,
    input  logic     sdi,
    output spi_evt_t evt
);
    localparam int STAGES = 2;

    logic [STAGES-1:0] cs_sync, sclk_sync, sdi_sync;
    logic              cs_prev, sclk_prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            cs_sync   <= '1;
            sclk_sync <= '0;
            sdi_sync  <= '0;
            cs_prev   <= 1'b1;
            sclk_prev <= 1'b0;
        end else begin
            cs_sync   <= {cs_sync[STAGES-2:0], cs_n};
            sclk_sync <= {sclk_sync[STAGES-2:0], sclk};
            sdi_sync  <= {sdi_sync[STAGES-2:0], sdi};
            cs_prev   <= cs_sync[STAGES-1];
            sclk_prev <= sclk_sync[STAGES-1];
        end
    end

    logic cs_s, sclk_s;
    assign cs_s   = cs_sync[STAGES-1];
    assign sclk_s = sclk_sync[STAGES-1];

    always_comb begin
        evt.frame_start = cs_prev && !cs_s;
        evt.frame_end   = !cs_prev && cs_s;
        evt.sclk_rise   = !sclk_prev && sclk_s && !cs_s;
        evt.sclk_fall   = sclk_prev && !sclk_s && !cs_s;
        evt.sdi_bit     = sdi_sync[STAGES-1];
    end

endmodule

// File: rtl/spi_frame_shifter.sv
module spi_frame_shifter
    import spi_cmd_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  spi_evt_t  evt,
    output logic      cmd_valid,
    output cmd_word_t cmd
);
    logic [WORD_W-1:0] shreg;
    logic [WORD_W-1:0] idr;
    logic [CNT_W-1:0]  bit_cnt;
    frame_kind_e       kind;

    assign kind = classify(bit_cnt);

    always_ff @(posedge clk) begin
        if (rst) begin
            shreg   <= '0;
            bit_cnt <= '0;
        end else if (evt.frame_start) begin
            shreg   <= '0;
            bit_cnt <= '0;
        end else if (evt.sclk_rise) begin
            shreg <= {shreg[WORD_W-2:0], evt.sdi_bit};
            if (bit_cnt != CNT_MAX)
                bit_cnt <= bit_cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            idr       <= '0;
            cmd_valid <= 1'b0;
        end else begin
            cmd_valid <= 1'b0;
            if (evt.frame_end && kind != FK_SHORT) begin
                idr       <= shreg;
                cmd_valid <= 1'b1;
            end
        end
    end

    assign cmd = cmd_word_t'(idr);

    p_cnt_sat_r3: assert property (@(posedge clk) disable iff (rst)
        (bit_cnt == CNT_MAX && !evt.frame_start) |=> bit_cnt == CNT_MAX);

    p_short_drop_r4: assert property (@(posedge clk) disable iff (rst)
        (evt.frame_end && bit_cnt < CNT_W'(WORD_W)) |=> (!cmd_valid && $stable(idr)));

    p_full_accept_r5: assert property (@(posedge clk) disable iff (rst)
        (evt.frame_end && bit_cnt >= CNT_W'(WORD_W)) |=> (cmd_valid && idr == $past(shreg)));

endmodule

// File: rtl/spi_ctrl_regbank.sv
module spi_ctrl_regbank
    import spi_cmd_pkg::*;
#(
    parameter int NREG = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_valid,
    input  cmd_word_t         cmd,
    input  logic              rsp_take,
    output logic              rsp_pending,
    output logic [DATA_W-1:0] rsp_data,
    output logic [NREG*DATA_W-1:0] regs_flat
);
    localparam int IDX_W = (NREG > 1) ? $clog2(NREG) : 1;

    logic [DATA_W-1:0] regs [NREG];
    logic              addr_ok;
    logic [IDX_W-1:0]  idx;
    logic              is_wr, is_rd;

    assign addr_ok = cmd.addr < ADDR_W'(NREG);
    assign idx     = cmd.addr[IDX_W-1:0];
    assign is_wr   = cmd_valid && cmd.opc == OPC_WRITE;
    assign is_rd   = cmd_valid && cmd.opc == OPC_READ;

    for (genvar g = 0; g < NREG; g++) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst)
                regs[g] <= '0;
            else if (is_wr && addr_ok && idx == IDX_W'(g))
                regs[g] <= cmd.wdata;
        end
        assign regs_flat[g*DATA_W +: DATA_W] = regs[g];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_pending <= 1'b0;
            rsp_data    <= '0;
        end else if (is_rd) begin
            rsp_pending <= 1'b1;
            rsp_data    <= addr_ok ? regs[idx] : '0;
        end else if (rsp_take) begin
            rsp_pending <= 1'b0;
        end
    end

    p_regs_hold_r7: assert property (@(posedge clk) disable iff (rst)
        !cmd_valid |=> $stable(regs_flat));

    p_read_arm_r8: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd.opc == OPC_READ) |=> rsp_pending);

    p_other_opc_r10: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd.opc != OPC_WRITE && cmd.opc != OPC_READ)
            |=> ($stable(regs_flat) && $stable(rsp_data)));

    p_rsp_consumed_r13: assert property (@(posedge clk) disable iff (rst)
        (rsp_pending && rsp_take && !cmd_valid) |=> !rsp_pending);

endmodule

// File: rtl/spi_sdo_shifter.sv
module spi_sdo_shifter
    import spi_cmd_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  spi_evt_t          evt,
    input  logic              rsp_pending,
    input  logic [DATA_W-1:0] rsp_data,
    input  logic [CONV_W-1:0] conv_data,
    output logic              sdo
);
    localparam int RSP_PAD  = WORD_W - DATA_W;
    localparam int CONV_PAD = WORD_W - CONV_W;

    logic [WORD_W-1:0] out_sr;

    always_ff @(posedge clk) begin
        if (rst || evt.frame_end)
            out_sr <= '0;
        else if (evt.frame_start)
            out_sr <= rsp_pending ? {rsp_data, {RSP_PAD{1'b0}}}
                                  : {conv_data, {CONV_PAD{1'b0}}};
        else if (evt.sclk_fall)
            out_sr <= {out_sr[WORD_W-2:0], 1'b0};
    end

    assign sdo = out_sr[WORD_W-1];

    p_sdo_quiet_r12: assert property (@(posedge clk) disable iff (rst)
        (!evt.sclk_fall && !evt.frame_start && !evt.frame_end) |=> $stable(sdo));

    p_sdo_idle_r1: assert property (@(posedge clk) disable iff (rst)
        evt.frame_end |=> !sdo);

endmodule

// File: rtl/spi_cmd_frame_rx.sv
module spi_cmd_frame_rx
    import spi_cmd_pkg::*;
#(
    parameter int NREG = 8
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     cs_n,
    input  logic                     sclk,
    input  logic                     sdi,
    input  logic [CONV_W-1:0]        conv_data,
    output logic                     sdo,
    output logic [NREG*DATA_W-1:0]   ctrl_regs
);
    spi_evt_t          evt;
    logic              cmd_valid;
    cmd_word_t         cmd;
    logic              rsp_pending;
    logic [DATA_W-1:0] rsp_data;

    spi_sync_edges u_sync (
        .clk  (clk),
        .rst  (rst),
        .cs_n (cs_n),
        .sclk (sclk),
        .sdi  (sdi),
        .evt  (evt)
    );

    spi_frame_shifter u_shift (
        .clk       (clk),
        .rst       (rst),
        .evt       (evt),
        .cmd_valid (cmd_valid),
        .cmd       (cmd)
    );

    spi_ctrl_regbank #(.NREG(NREG)) u_regs (
        .clk         (clk),
        .rst         (rst),
        .cmd_valid   (cmd_valid),
        .cmd         (cmd),
        .rsp_take    (evt.frame_start),
        .rsp_pending (rsp_pending),
        .rsp_data    (rsp_data),
        .regs_flat   (ctrl_regs)
    );

    spi_sdo_shifter u_sdo (
        .clk         (clk),
        .rst         (rst),
        .evt         (evt),
        .rsp_pending (rsp_pending),
        .rsp_data    (rsp_data),
        .conv_data   (conv_data),
        .sdo         (sdo)
    );

    p_regs_zero_after_reset_r1: assert property (@(posedge clk)
        $past(rst) |-> ctrl_regs == '0);

endmodule

// File: tb/spi_cmd_frame_rx_test.sv
module spi_cmd_frame_rx_test;
    localparam int NREG = 8;
    localparam int HALF = 6;
    localparam int NVEC = 12;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cs_n = 1'b1;
    logic sclk = 1'b0;
    logic sdi = 1'b0;
    logic [15:0] conv_data = '0;
    logic sdo;
    logic [NREG*8-1:0] ctrl_regs;

    int n_run = 0;
    int n_fail = 0;

    // model state, built from the requirements
    logic [7:0] m_regs [NREG];
    logic       m_pend;
    logic [7:0] m_rdata;

    always #2.5 clk = ~clk;

    spi_cmd_frame_rx #(.NREG(NREG)) uut (
        .clk(clk), .rst(rst), .cs_n(cs_n), .sclk(sclk), .sdi(sdi),
        .conv_data(conv_data), .sdo(sdo), .ctrl_regs(ctrl_regs)
    );

    // entry: {nbits[7:0], frame bits right-justified[47:0], conv[15:0]}
    localparam logic [71:0] VECS [NVEC] = '{
        {8'd22, 48'h000000_040300, 16'h1234},  // read reg3 (R8, R9, R1)
        {8'd22, 48'h000000_0203A5, 16'hBEEF},  // write reg3, returns reg3=0
        {8'd22, 48'h000000_040300, 16'h0F0F},  // read reg3
        {8'd22, 48'h000000_060311, 16'h8001},  // opcode 00011 nop (R10)
        {8'd10, 48'h000000_0003FF, 16'h7FFF},  // short (R4)
        {8'd30, 48'h000000_FF02053C, 16'h0001},// long write reg5 (R6)
        {8'd22, 48'h000000_040500, 16'hAAAA},  // read reg5
        {8'd22, 48'h000000_02C877, 16'h5555},  // write addr 200 (R11)
        {8'd22, 48'h000000_04C800, 16'h5A5A},  // read addr 200 (R11)
        {8'd14, 48'h000000_00205A, 16'h1111},  // short takes response (R13)
        {8'd22, 48'h000000_0207FF, 16'h2222},  // write reg7
        {8'd22, 48'h000000_020081, 16'h3333}   // write reg0
    };

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    function automatic logic [NREG*8-1:0] model_flat();
        logic [NREG*8-1:0] f;
        for (int i = 0; i < NREG; i++) f[i*8 +: 8] = m_regs[i];
        return f;
    endfunction

    // Runs one frame, checks SDO against the model, then updates the model.
    task automatic frame(input int nbits, input logic [127:0] bits, input logic [15:0] conv);
        logic [21:0] exp_sdo;
        logic [21:0] word;
        int bad_tail;
        logic [21:0] got;
        got = '0;
        bad_tail = 0;
        exp_sdo = m_pend ? {m_rdata, 14'b0} : {conv, 6'b0};
        conv_data = conv;
        @(negedge clk);
        cs_n = 1'b0;
        wait_clk(10);
        conv_data = ~conv;  // value after the falling edge must not matter (R9)
        for (int i = nbits - 1; i >= 0; i--) begin
            int pos;
            pos = nbits - 1 - i;
            sdi = bits[i];
            wait_clk(HALF);
            if (pos < 22) got[21 - pos] = sdo;
            else if (sdo !== 1'b0) bad_tail++;
            sclk = 1'b1;
            wait_clk(HALF);
            sclk = 1'b0;
        end
        wait_clk(HALF);
        cs_n = 1'b1;
        wait_clk(10);
        if (nbits >= 22) begin
            check("R9/R8/R12 sdo word", 64'(got), 64'(exp_sdo));
        end else begin
            logic [21:0] mask;
            mask = ~(22'h3FFFFF >> nbits);
            check("R12/R13 sdo short prefix", 64'(got & mask), 64'(exp_sdo & mask));
        end
        if (nbits > 22) check("R12 sdo zero tail", 64'(bad_tail), 64'd0);
        // model update
        m_pend = 1'b0;
        if (nbits >= 22) begin
            word = bits[21:0];
            if (word[21:17] == 5'b00001) begin
                if (word[16:8] < NREG) m_regs[word[10:8]] = word[7:0];
            end else if (word[21:17] == 5'b00010) begin
                m_pend  = 1'b1;
                m_rdata = (word[16:8] < NREG) ? m_regs[word[10:8]] : 8'h00;
            end
        end
        check("R7/R4/R5/R6/R10/R11 ctrl_regs", 64'(ctrl_regs), 64'(model_flat()));
    endtask

    initial begin
        #400000;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        for (int i = 0; i < NREG; i++) m_regs[i] = 8'h00;
        m_pend = 1'b0;
        m_rdata = 8'h00;
        wait_clk(5);
        rst = 1'b0;
        wait_clk(5);
        // R1: reset state
        check("R1 ctrl_regs after reset", 64'(ctrl_regs), 64'd0);
        check("R1 sdo idle", 64'(sdo), 64'd0);

        // table walk
        for (int v = 0; v < NVEC; v++) begin
            frame(int'(VECS[v][71:64]), 128'(VECS[v][63:16]), VECS[v][15:0]);
        end

        // R3: 70-clock frame, saturating counter, write reg1 = 5A right-justified
        frame(70, {80'h0, {26{1'b1}}, 22'h02015A}, 16'hC3C3);
        check("R3 reg1 after 70-clock frame", 64'(ctrl_regs[15:8]), 64'h5A);
        // R8/R2: read it back
        frame(22, 128'h040100, 16'h0001);
        frame(22, 128'h000000, 16'h9876);  // returns 5A, then R13 back to conv
        frame(22, 128'h000000, 16'h4321);

        // R4: 21-clock frame holding a write whose low bits shift in
        frame(21, 128'h010299, 16'h0102);
        check("R4 reg2 untouched by 21-clock frame", 64'(ctrl_regs[23:16]), 64'h00);

        // R1: reset again clears everything
        @(negedge clk);
        rst = 1'b1;
        wait_clk(3);
        rst = 1'b0;
        wait_clk(5);
        for (int i = 0; i < NREG; i++) m_regs[i] = 8'h00;
        m_pend = 1'b0;
        check("R1 ctrl_regs after second reset", 64'(ctrl_regs), 64'd0);
        frame(22, 128'h000000, 16'hFEDC);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule